// File: doc/BRIEF.md
# Vector Register Group Legality Checker

This block sits in the decode stage of a vector unit. For each instruction it is handed a destination register index, one source register index, the active group multiplier setting and the element widths of both operands. It then decides whether the register groups named by those operands are legal.

The destination group size comes from the group multiplier. The source group size is scaled by the ratio of source to destination element width. Both groups must start on a register index aligned to their own size. Where the two groups overlap, the overlap is only accepted in the forms that a narrowing or widening operation can tolerate. The verdict is registered and presented one cycle after the request, together with its own valid.

Top module: `vreg_group_checker`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high, and low one cycle after `in_valid` was low. `out_illegal` is never high while `out_valid` is low.
- R2: `grp_mult` codes 0,1,2,3 select 1,2,4,8 registers per group. Codes 5,6,7 select the fractions 1/8, 1/4 and 1/2. Code 4 is reserved and always yields `out_illegal`=1. The width codes 0..3 on `dst_ew` and `src_ew` mean 8, 16, 32 and 64 bit elements.
- R3: With a whole multiplier of N, `vd_idx` must be a multiple of N, otherwise illegal. A fractional multiplier puts no alignment constraint on `vd_idx`.
- R4: The source multiplier equals the group multiplier times src width divided by dst width. If it is N≥1, `vs_idx` must be a multiple of N, otherwise illegal. A fractional source multiplier occupies one register and has no alignment constraint.
- R5: A source multiplier above 8 or below 1/8 is illegal.
- R6: When both element widths are equal, any overlap of the two groups is allowed.
- R7: When the dst width is smaller than the src width, an overlap is legal only if `vd_idx` equals `vs_idx`, i.e. it is the lowest register of the source group.
- R8: When the dst width is larger than the src width, an overlap is legal only if the source multiplier is at least 1 and the source group ends on the same register as the destination group. Any overlap with a fractional source multiplier is illegal.
- R9: An aligned, in-range pair of groups that do not overlap is legal, whatever the element widths are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| vd_idx | input | 5 | Destination register index |
| vs_idx | input | 5 | Source register index |
| grp_mult | input | 3 | Group multiplier code |
| dst_ew | input | 2 | Destination element width code |
| src_ew | input | 2 | Source element width code |
| out_valid | output | 1 | Verdict valid, one cycle after the request |
| out_illegal | output | 1 | Verdict: 1 = illegal register group use |

## Verification
Directed requests cover four kinds of case. Widening requests at multiplier 8 separate a source that ends with the destination group from one that starts or sits inside it. Narrowing requests at multiplier 1 separate a destination at the source base from one on the next register. Misaligned destination and source indices separate destination alignment from source alignment checking. Fractional and reserved multipliers probe the range limits and the treatment of fractional source groups. A long run of random requests is then compared against an independent integer model that works in eighths of a register, which exercises the equal-width rule and the non-overlap rule across all codes.

// File: rtl/vgc_pkg.sv
package vgc_pkg;
  localparam int MAX_LOG = 3;               // largest group is 2**MAX_LOG registers
  localparam int LOG_W   = 4;               // signed log2 multiplier width
  localparam int GRP_W   = MAX_LOG + 1;     // width of a register count
  localparam logic [2:0] MULT_RSVD = 3'b100;

  typedef logic signed [LOG_W-1:0] mlog_t;
  typedef logic [GRP_W-1:0] grp_t;

  // Multiplier code as signed log2: 0..3 -> 0..3, 5..7 -> -3..-1, 4 -> -4
  function automatic mlog_t mult_log(input logic [2:0] code);
    return mlog_t'({code[2], code});
  endfunction

  // Registers occupied by a group of log2 multiplier e (fractional -> 1)
  function automatic grp_t grp_regs(input mlog_t e);
    if (e <= 0) return grp_t'(1);
    return grp_t'(1) << e[1:0];
  endfunction

  // Source log2 multiplier scaled by element width ratio
  function automatic mlog_t src_log(input mlog_t lm, input logic [1:0] dw,
                                    input logic [1:0] sw);
    return lm + mlog_t'({2'b00, sw}) - mlog_t'({2'b00, dw});
  endfunction
endpackage

// File: rtl/vgc_align.sv
module vgc_align
  import vgc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  input  mlog_t            elog,
  output logic             misaligned,
  output logic [IDX_W:0]   first,
  output logic [IDX_W:0]   last
);
  grp_t regs;

  always_comb begin
    regs       = grp_regs(elog);
    misaligned = |(idx & IDX_W'(regs - grp_t'(1)));
    first      = {1'b0, idx};
    last       = {1'b0, idx} + (IDX_W+1)'(regs) - (IDX_W+1)'(1);
  end
endmodule

// File: rtl/vgc_overlap.sv
module vgc_overlap
  import vgc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W:0] d_first,
  input  logic [IDX_W:0] d_last,
  input  logic [IDX_W:0] s_first,
  input  logic [IDX_W:0] s_last,
  input  logic [1:0]     dst_ew,
  input  logic [1:0]     src_ew,
  input  mlog_t          slog,
  output logic           hit,
  output logic           bad
);
  always_comb begin
    hit = (s_first <= d_last) && (d_first <= s_last);
    if (dst_ew == src_ew)
      bad = 1'b0;
    else if (dst_ew < src_ew)
      bad = hit && (d_first != s_first);
    else
      bad = hit && ((slog < 0) || (s_last != d_last));
  end
endmodule

// File: rtl/vreg_group_checker.sv
module vreg_group_checker
  import vgc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] vd_idx,
  input  logic [IDX_W-1:0] vs_idx,
  input  logic [2:0]       grp_mult,
  input  logic [1:0]       dst_ew,
  input  logic [1:0]       src_ew,
  output logic             out_valid,
  output logic             out_illegal
);
  localparam mlog_t LOG_HI = mlog_t'(MAX_LOG);
  localparam mlog_t LOG_LO = -mlog_t'(MAX_LOG);

  mlog_t dlog, slog;
  logic  mult_rsvd, src_range_bad;
  logic  dst_misaligned, src_misaligned;
  logic  overlap_hit, overlap_bad, fault;
  logic [IDX_W:0] d_first, d_last, s_first, s_last;

  always_comb begin
    dlog          = mult_log(grp_mult);
    slog          = src_log(dlog, dst_ew, src_ew);
    mult_rsvd     = (grp_mult == MULT_RSVD);
    src_range_bad = (slog > LOG_HI) || (slog < LOG_LO);
  end

  vgc_align #(.IDX_W(IDX_W)) u_dst (
    .idx(vd_idx), .elog(dlog), .misaligned(dst_misaligned),
    .first(d_first), .last(d_last)
  );

  vgc_align #(.IDX_W(IDX_W)) u_src (
    .idx(vs_idx), .elog(slog), .misaligned(src_misaligned),
    .first(s_first), .last(s_last)
  );

  vgc_overlap #(.IDX_W(IDX_W)) u_ovl (
    .d_first(d_first), .d_last(d_last), .s_first(s_first), .s_last(s_last),
    .dst_ew(dst_ew), .src_ew(src_ew), .slog(slog),
    .hit(overlap_hit), .bad(overlap_bad)
  );

  assign fault = mult_rsvd | src_range_bad | dst_misaligned |
                 src_misaligned | overlap_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid & fault;
    end
  end

  // R1: verdict timing and gating
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_flag_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_illegal);
  // R2: reserved multiplier code
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && grp_mult == MULT_RSVD |=> out_illegal);
  // R3: destination alignment
  a_r3_dst_align: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dst_misaligned |=> out_illegal);
  // R4: source alignment
  a_r4_src_align: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src_misaligned |=> out_illegal);
  // R5: source multiplier range
  a_r5_src_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src_range_bad |=> out_illegal);
  // R6: equal widths never fail on overlap alone
  a_r6_equal_free: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dst_ew == src_ew && !mult_rsvd && !dst_misaligned &&
    !src_misaligned && !src_range_bad |=> !out_illegal);
  // R8: fractional source overlapping a wider destination
  a_r8_frac_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dst_ew > src_ew && slog < 0 && overlap_hit |=> out_illegal);
  // R9: disjoint aligned groups pass
  a_r9_disjoint_ok: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !overlap_hit && !mult_rsvd && !dst_misaligned &&
    !src_misaligned && !src_range_bad |=> !out_illegal);
endmodule

// File: tb/vreg_group_checker_test.sv
`timescale 1ns/1ps
module vreg_group_checker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] vd_idx = '0, vs_idx = '0;
  logic [2:0] grp_mult = '0;
  logic [1:0] dst_ew = '0, src_ew = '0;
  logic       out_valid, out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { bit exp; string tag; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  vreg_group_checker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .vd_idx(vd_idx), .vs_idx(vs_idx), .grp_mult(grp_mult),
    .dst_ew(dst_ew), .src_ew(src_ew),
    .out_valid(out_valid), .out_illegal(out_illegal)
  );

  // Independent model: multipliers counted in eighths of a register
  function automatic bit model(int vd, int vs, int lc, int de, int se);
    int l8, s8, dn, sn;
    case (lc)
      0: l8 = 8;  1: l8 = 16; 2: l8 = 32; 3: l8 = 64;
      5: l8 = 1;  6: l8 = 2;  7: l8 = 4;
      default: return 1'b1;
    endcase
    s8 = l8 * (1 << se) / (1 << de);
    if (s8 < 1 || s8 > 64) return 1'b1;
    dn = (l8 < 8) ? 1 : l8 / 8;
    sn = (s8 < 8) ? 1 : s8 / 8;
    if (vd % dn != 0 || vs % sn != 0) return 1'b1;
    if (!(vs <= vd + dn - 1 && vd <= vs + sn - 1)) return 1'b0;
    if (de == se) return 1'b0;
    if (de < se) return vd != vs;
    return (s8 < 8) || (vs + sn != vd + dn);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int vd, int vs, int lc, int de, int se, string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    vd_idx = 5'(vd); vs_idx = 5'(vs); grp_mult = 3'(lc);
    dst_ew = 2'(de); src_ew = 2'(se);
    it.exp = model(vd, vs, lc, de, se);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare each verdict with the oldest expected item
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && !done) begin
        if (out_valid) begin
          if (sb.size() == 0) check(0, "R1 unexpected out_valid", 1, 0);
          else begin
            it = sb.pop_front();
            check(out_illegal == it.exp, it.tag, out_illegal, it.exp);
          end
        end else if (out_illegal) begin
          check(0, "R1 flag without valid", 1, 0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(out_illegal == 1'b0, "R1 reset out_illegal", out_illegal, 0);
    @(negedge clk); rst_n = 1'b1;

    send(3, 5, 4, 0, 0, "R2 reserved code");
    send(3, 5, 7, 1, 1, "R2 half multiplier legal");
    idle();
    send(4, 16, 3, 3, 0, "R3 vd v4 at x8 misaligned");
    send(4, 8, 2, 2, 2, "R3 vd v4 at x4 aligned");
    send(2, 1, 1, 1, 0, "R4 x2 zero-ext source x1");
    send(0, 3, 2, 1, 0, "R4 source v3 misaligned at x2");
    send(0, 0, 3, 0, 1, "R5 source multiplier 16");
    send(4, 9, 5, 1, 0, "R5 source multiplier 1/16");
    send(4, 4, 1, 2, 2, "R6 equal widths full overlap");
    idle();
    send(0, 0, 0, 0, 1, "R7 narrow vd=vs");
    send(1, 0, 0, 0, 1, "R7 narrow vd v1 vs v0");
    send(0, 6, 3, 2, 0, "R8 widen vs v6 top");
    send(0, 0, 3, 2, 0, "R8 widen vs v0");
    send(0, 2, 3, 2, 0, "R8 widen vs v2");
    send(0, 4, 3, 2, 0, "R8 widen vs v4");
    send(2, 2, 0, 3, 0, "R8 fractional source overlap");
    send(5, 5, 7, 1, 0, "R8 half-mult fractional overlap");
    send(2, 3, 0, 3, 0, "R9 fractional source disjoint");
    send(0, 8, 3, 2, 0, "R9 widen disjoint");
    idle();
    for (int i = 0; i < 3000; i++) begin
      send($urandom_range(0, 31), $urandom_range(0, 31),
           $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 3), "R9 random sweep");
      if (i % 7 == 0) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R1 all verdicts delivered", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule